// File: doc/BRIEF.md
# Multiplexed Grid Scanner with Brightness Control

This block drives a dot-matrix vacuum-fluorescent style display of up to 24 digits from the oscillator clock. It walks the digit grids one at a time in ascending order. Each grid gets a fixed time slot of 1024 clocks. At the start of the slot the grid is lit for a programmable number of clocks, and it stays dark for the rest of the slot. During that slot the block presents the 35 dot anodes and the 4 auxiliary anodes that belong to the lit digit.

For each digit the block fetches an 8-bit character code and a 4-bit symbol word from external storage, one slot ahead of display. Small codes select a user-defined pattern held in an external pattern RAM. All other codes select a built-in pattern generator, which here is a deterministic stub that stands in for the character ROM. All external reads have a one-cycle latency. A 10-bit brightness value, a 4-bit digit-count setting and two anode override flags shape the output.

Top module: `grid_scan`

## Requirements
- R1: Each digit slot lasts exactly 1024 clocks. The grid of the current digit is high for the first min(duty_val, 960) clocks of the slot and low for the remaining clocks, so the blank gap is at least 64 clocks.
- R2: When duty_val is 0, every grid output stays low at all times.
- R3: A digit_cnt of 0 scans 24 digits. A value k from 1 to 15 scans k+8 digits. Digits are strobed in ascending order starting at grid bit 0 and wrap back to bit 0 after the last active digit. At most one grid bit is high at any time, and grids above the last active digit never go high.
- R4: A character code below 16 selects pat_data, read at pat_addr = code[3:0]. A code of 16 or above selects the built-in pattern, in which bit n equals code bit (n mod 8); this gives {code[2:0], code, code, code, code}. Pattern bit n drives seg[n].
- R5: Symbol bit n drives ad[n] directly, with no pattern lookup.
- R6: The override flags act on seg and ad only:
  - all_on set: every seg and ad bit is 1, whatever all_off holds.
  - all_off set with all_on clear: every seg and ad bit is 0.
  - both flags clear: normal display.

  The flags are sampled when a new slot's anode data is loaded.
- R7: While rst_n is low, every grid, seg and ad output is low. After release, the first slot is dark. Grid bit 0 goes high 1024 clocks after release.
- R8: seg and ad change only on the first cycle of a slot, and the cycle before that change always has every grid low. They hold steady while a grid is lit.
- R9: Throughout a slot, digit_addr holds the index of the digit to be shown in the next slot. The char_code, sym_bits and pat_data inputs are consumed one cycle after their address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_val | input | 10 | Grid on-time in clocks per slot, clamped at 960 |
| digit_cnt | input | 4 | Active digit count: 0 means 24, k means k+8 |
| all_on | input | 1 | Force all anodes high |
| all_off | input | 1 | Force all anodes low (when all_on is clear) |
| digit_addr | output | 5 | Digit index for the code and symbol reads |
| char_code | input | 8 | Character code read at digit_addr, one cycle latency |
| sym_bits | input | 4 | Symbol word read at digit_addr, one cycle latency |
| pat_addr | output | 4 | Pattern RAM index taken from the low code bits |
| pat_data | input | 35 | Pattern RAM word, one cycle latency |
| grid | output | 24 | Grid strobes, at most one high |
| seg | output | 35 | Dot anodes |
| ad | output | 4 | Auxiliary anodes |

## Verification
A wrong slot counter or clamp shows up within one slot as an on-time or gap count that differs from min(duty,960) and its complement. A wrong digit index or wrap limit shows up within one frame as a grid bit out of sequence or a frame length that does not match the digit count. A fetch pipeline that is off by a cycle, or a wrong RAM/ROM select, puts a neighbouring digit's pattern on the very first slot in which the stale data is used. Anode changes while a grid is lit are caught in the cycle they happen.

// File: rtl/gs_pkg.sv
package gs_pkg;

   typedef enum logic [1:0] {
      AM_NORMAL = 2'd0,
      AM_DARK   = 2'd1,
      AM_LIT    = 2'd2
   } anode_mode_e;

   // Lit takes priority over dark.
   function automatic anode_mode_e anode_mode(input logic lit_f, input logic dark_f);
      if (lit_f)  return AM_LIT;
      if (dark_f) return AM_DARK;
      return AM_NORMAL;
   endfunction

endpackage

// File: rtl/gs_timer.sv
module gs_timer #(
   parameter int SLOT_LEN = 1024,
   parameter int MAX_DIG  = 24,
   parameter int DIG_OFS  = 8,
   parameter int CNT_W    = 4,
   localparam int TICK_W  = $clog2(SLOT_LEN),
   localparam int DIG_W   = $clog2(MAX_DIG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_code,
   output logic [TICK_W-1:0] tick,
   output logic [DIG_W-1:0]  dig,
   output logic [DIG_W-1:0]  nxt_dig,
   output logic              live,
   output logic              slot_end
);

   if (SLOT_LEN < 8) begin : g_bad_slot
      $error("SLOT_LEN too short for the fetch pipeline");
   end
   if ((2**CNT_W) - 1 + DIG_OFS > MAX_DIG) begin : g_bad_cnt
      $error("digit count encoding exceeds MAX_DIG");
   end

   logic [DIG_W-1:0] last_idx;

   always_comb begin
      if (cnt_code == '0) last_idx = DIG_W'(MAX_DIG - 1);
      else                last_idx = DIG_W'(cnt_code) + DIG_W'(DIG_OFS - 1);
   end

   assign slot_end = (tick == TICK_W'(SLOT_LEN - 1));
   assign nxt_dig  = (dig >= last_idx) ? '0 : dig + DIG_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick <= '0;
         dig  <= DIG_W'(MAX_DIG - 1);
         live <= 1'b0;
      end else begin
         tick <= slot_end ? '0 : tick + TICK_W'(1);
         if (slot_end) begin
            dig  <= nxt_dig;
            live <= 1'b1;
         end
      end
   end

   p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end |=> (dig == '0 || dig == $past(dig) + DIG_W'(1)));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && dig >= last_idx) |=> dig == '0);

   p_first_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live) |-> dig == '0);

endmodule

// File: rtl/gs_fetch.sv
module gs_fetch
   import gs_pkg::*;
#(
   parameter int SEG_W     = 35,
   parameter int AD_W      = 4,
   parameter int CODE_W    = 8,
   parameter int RAM_CODES = 16,
   parameter int SLOT_LEN  = 1024,
   localparam int TICK_W   = $clog2(SLOT_LEN),
   localparam int PA_W     = $clog2(RAM_CODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic              all_on,
   input  logic              all_off,
   input  logic [CODE_W-1:0] char_code,
   input  logic [AD_W-1:0]   sym_bits,
   input  logic [SEG_W-1:0]  pat_data,
   output logic [PA_W-1:0]   pat_addr,
   output logic [SEG_W-1:0]  seg,
   output logic [AD_W-1:0]   ad
);

   if ((2**PA_W) != RAM_CODES || RAM_CODES >= (2**CODE_W)) begin : g_bad_ram
      $error("RAM_CODES must be a power of two below the code space");
   end

   // Capture codes two cycles before the slot ends.
   // The RAM word is back one cycle later and is loaded on the last tick.
   logic              cap, load;
   logic [CODE_W-1:0] code_q;
   logic [AD_W-1:0]   sym_q;
   logic [SEG_W-1:0]  rom_pat, pattern;
   anode_mode_e       mode;

   assign cap      = (tick == TICK_W'(SLOT_LEN - 3));
   assign load     = (tick == TICK_W'(SLOT_LEN - 1));
   assign pat_addr = code_q[PA_W-1:0];
   assign mode     = anode_mode(all_on, all_off);

   // Pattern generator stub: code bits repeated across the segment field.
   always_comb begin
      for (int i = 0; i < SEG_W; i++) rom_pat[i] = code_q[i % CODE_W];
   end

   assign pattern = (code_q < CODE_W'(RAM_CODES)) ? pat_data : rom_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         sym_q  <= '0;
         seg    <= '0;
         ad     <= '0;
      end else begin
         if (cap) begin
            code_q <= char_code;
            sym_q  <= sym_bits;
         end
         if (load) begin
            unique case (mode)
               AM_LIT:  begin seg <= '1;      ad <= '1;    end
               AM_DARK: begin seg <= '0;      ad <= '0;    end
               default: begin seg <= pattern; ad <= sym_q; end
            endcase
         end
      end
   end

   p_force_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && all_on) |=> (&seg && &ad));

   p_force_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && all_off && !all_on) |=> (seg == '0 && ad == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(seg) && $stable(ad)));

endmodule

// File: rtl/grid_scan.sv
module grid_scan #(
   parameter int SLOT_LEN  = 1024,
   parameter int ON_MAX    = 960,
   parameter int DUTY_W    = 10,
   parameter int MAX_DIG   = 24,
   parameter int DIG_OFS   = 8,
   parameter int CNT_W     = 4,
   parameter int SEG_W     = 35,
   parameter int AD_W      = 4,
   parameter int CODE_W    = 8,
   parameter int RAM_CODES = 16,
   localparam int TICK_W   = $clog2(SLOT_LEN),
   localparam int DIG_W    = $clog2(MAX_DIG),
   localparam int PA_W     = $clog2(RAM_CODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_val,
   input  logic [CNT_W-1:0]  digit_cnt,
   input  logic              all_on,
   input  logic              all_off,
   output logic [DIG_W-1:0]  digit_addr,
   input  logic [CODE_W-1:0] char_code,
   input  logic [AD_W-1:0]   sym_bits,
   output logic [PA_W-1:0]   pat_addr,
   input  logic [SEG_W-1:0]  pat_data,
   output logic [MAX_DIG-1:0] grid,
   output logic [SEG_W-1:0]  seg,
   output logic [AD_W-1:0]   ad
);

   if (ON_MAX > SLOT_LEN - 4) begin : g_bad_on
      $error("ON_MAX leaves no blank time for the fetch");
   end
   if ((2**DUTY_W) <= ON_MAX) begin : g_bad_duty
      $error("DUTY_W cannot reach ON_MAX");
   end

   logic [TICK_W-1:0] tick, on_eff;
   logic [DIG_W-1:0]  dig, nxt_dig;
   logic              live, slot_end, show;

   gs_timer #(
      .SLOT_LEN(SLOT_LEN), .MAX_DIG(MAX_DIG), .DIG_OFS(DIG_OFS), .CNT_W(CNT_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .cnt_code(digit_cnt),
      .tick(tick), .dig(dig), .nxt_dig(nxt_dig), .live(live), .slot_end(slot_end)
   );

   gs_fetch #(
      .SEG_W(SEG_W), .AD_W(AD_W), .CODE_W(CODE_W),
      .RAM_CODES(RAM_CODES), .SLOT_LEN(SLOT_LEN)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .all_on(all_on), .all_off(all_off),
      .char_code(char_code), .sym_bits(sym_bits), .pat_data(pat_data),
      .pat_addr(pat_addr), .seg(seg), .ad(ad)
   );

   assign digit_addr = nxt_dig;

   always_comb begin
      if (duty_val >= DUTY_W'(ON_MAX)) on_eff = TICK_W'(ON_MAX);
      else                             on_eff = TICK_W'(duty_val);
   end

   assign show = live && (tick < on_eff);

   for (genvar g = 0; g < MAX_DIG; g++) begin : g_grid
      assign grid[g] = show && (dig == DIG_W'(g));
   end

   p_grid_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grid));

   p_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (grid != '0) |-> (tick < TICK_W'(ON_MAX)));

   p_seg_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(seg) || !$stable(ad)) |-> ($past(grid) == '0));

   p_duty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_val == '0) |-> (grid == '0));

   p_last_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end |=> (live && grid == '0) || (grid != '0 && $onehot(grid)));

endmodule

// File: tb/sim_grid_scan.sv
`timescale 1ns/1ps
module sim_grid_scan;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  duty_val = '0;
   logic [3:0]  digit_cnt = '0;
   logic        all_on = 1'b0, all_off = 1'b0;
   logic [4:0]  digit_addr;
   logic [7:0]  code_rd = '0;
   logic [3:0]  sym_rd = '0;
   logic [3:0]  pat_addr;
   logic [34:0] pat_rd = '0;
   logic [23:0] grid;
   logic [34:0] seg;
   logic [3:0]  ad;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   grid_scan u0 (
      .clk(clk), .rst_n(rst_n), .duty_val(duty_val), .digit_cnt(digit_cnt),
      .all_on(all_on), .all_off(all_off), .digit_addr(digit_addr),
      .char_code(code_rd), .sym_bits(sym_rd), .pat_addr(pat_addr),
      .pat_data(pat_rd), .grid(grid), .seg(seg), .ad(ad)
   );

   function automatic logic [7:0] code_of(input logic [4:0] a);
      if (a % 3 == 0) return {4'h0, a[3:0]};
      return 8'h40 + 8'(a) * 8'd5;
   endfunction

   function automatic logic [3:0] sym_of(input logic [4:0] a);
      return a[3:0] ^ 4'h5;
   endfunction

   function automatic logic [34:0] pat_of(input logic [3:0] i);
      return {3'b011, 8'h9C, {4'h0, i}, ~{4'h0, i}, {i, 4'h0} ^ 8'h3C};
   endfunction

   function automatic logic [34:0] rom_of(input logic [7:0] c);
      return {c[2:0], c, c, c, c};
   endfunction

   function automatic logic [34:0] exp_seg(input int d, input logic on, input logic off);
      logic [7:0] c;
      c = code_of(5'(d));
      if (on)  return '1;
      if (off) return '0;
      return (c < 8'd16) ? pat_of(c[3:0]) : rom_of(c);
   endfunction

   function automatic logic [3:0] exp_ad(input int d, input logic on, input logic off);
      if (on)  return '1;
      if (off) return '0;
      return sym_of(5'(d));
   endfunction

   // External memories with one-cycle read latency
   always @(posedge clk) begin
      code_rd <= code_of(digit_addr);
      sym_rd  <= sym_of(digit_addr);
      pat_rd  <= pat_of(pat_addr);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_com1();
      logic [23:0] prv;
      prv = grid;
      forever begin
         @(negedge clk);
         if (grid == 24'd1 && prv == 24'd0) break;
         prv = grid;
      end
   endtask

   // {duty, cnt, all_on, all_off, expected on-time, expected digits}
   localparam logic [31:0] VEC [5] = '{
      {10'h3C0, 4'h0, 1'b0, 1'b0, 11'd960, 5'd24},
      {10'h3FF, 4'h1, 1'b1, 1'b0, 11'd960, 5'd9},
      {10'h001, 4'h1, 1'b0, 1'b1, 11'd1,   5'd9},
      {10'h200, 4'h2, 1'b1, 1'b1, 11'd512, 5'd10},
      {10'h064, 4'hF, 1'b0, 1'b0, 11'd100, 5'd23}
   };

   initial begin : wdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R7: outputs low while in reset
      chk("R7 grid in reset", 64'(grid), 64'd0);
      chk("R7 seg in reset", 64'(seg), 64'd0);
      chk("R7 ad in reset", 64'(ad), 64'd0);
      rst_n = 1'b1;

      for (int v = 0; v < 5; v++) begin
         logic [31:0] w;
         int exp_on, nd, cnt, off, bad;
         logic [34:0] s0;
         logic [3:0]  a0;
         w = VEC[v];
         duty_val  = w[31:22];
         digit_cnt = w[21:18];
         all_on    = w[17];
         all_off   = w[16];
         exp_on    = int'(w[15:5]);
         nd        = int'(w[4:0]);
         wait_com1();
         bad = 0;
         for (int d = 0; d < nd; d++) begin
            chk("R3 grid order", 64'(grid), 64'(24'd1 << d));
            chk("R4/R6 seg", 64'(seg), 64'(exp_seg(d, all_on, all_off)));
            chk("R5/R6 ad", 64'(ad), 64'(exp_ad(d, all_on, all_off)));
            s0 = seg; a0 = ad; cnt = 0;
            while (grid == (24'd1 << d)) begin
               cnt++;
               if (seg !== s0 || ad !== a0) bad++;
               @(negedge clk);
            end
            chk("R1 blank after on-time", 64'(grid), 64'd0);
            off = 0;
            while (grid == 24'd0) begin
               off++;
               @(negedge clk);
            end
            chk("R1 on-time", 64'(cnt), 64'(exp_on));
            chk("R1 blank length", 64'(off), 64'(1024 - exp_on));
         end
         chk("R3 wrap to first grid", 64'(grid), 64'd1);
         chk("R8 anodes steady while lit", 64'(bad), 64'd0);
      end

      // R2: duty zero keeps all grids dark
      begin
         int lit;
         duty_val = '0; digit_cnt = 4'h1; all_on = 1'b0; all_off = 1'b0;
         lit = 0;
         repeat (2100) begin
            @(negedge clk);
            if (grid != 24'd0) lit++;
         end
         chk("R2 grids dark at duty 0", 64'(lit), 64'd0);
      end

      // R7: reset mid-run, first slot dark, COM1 after 1024 clocks
      begin
         int waitc;
         duty_val = 10'h3C0; digit_cnt = 4'h0;
         rst_n = 1'b0;
         repeat (2) @(negedge clk);
         chk("R7 grid after reset", 64'(grid), 64'd0);
         chk("R7 seg after reset", 64'(seg), 64'd0);
         chk("R7 ad after reset", 64'(ad), 64'd0);
         rst_n = 1'b1;
         waitc = 0;
         while (grid == 24'd0 && waitc < 3000) begin
            @(negedge clk);
            waitc++;
         end
         chk("R7 first grid delay", 64'(waitc), 64'd1024);
         chk("R7 first grid is COM1", 64'(grid), 64'd1);
         chk("R9 first digit data", 64'(seg), 64'(exp_seg(0, 1'b0, 1'b0)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule